// File: doc/BRIEF.md
# Local Countdown Timer with Divided Timebase

This block counts down a programmed initial value, one step per divided timebase tick, and raises a one-cycle interrupt request carrying a programmed vector when the count runs out. The timebase is an external bus tick strobe; a three-bit divide code, spread over bits 3, 1 and 0 of the divide register, selects a prescale ratio from 1 to 128. The timer runs either once (stopping at zero) or periodically (reloading the initial value after each expiry).

Besides the timer's own entry, the block keeps a bank of six local interrupt entries (vector and mask, plus a periodic bit on the timer entry). A global software-enable input gates delivery: while it is low every entry is held masked and entry writes land masked. Software accesses the registers through a plain write strobe with a select code and a combinational read port.

Top module: `irq_countdown_timer`

## Requirements
- R1: The divide register stores bits 3, 1 and 0 (bit 2 and all others read 0). The code c = {bit3, bit1, bit0} gives a ratio of 2^((c+1) mod 8): code 0 divides by 2, code 6 by 128, code 7 by 1. A divided tick occurs on every ratio-th bus tick counted since the last restart.
- R2: Writing the initial-count register (select 0) loads both the initial and current count with the written value and restarts the prescaler, cancelling any count in progress; a bus tick in the same cycle is discarded.
- R3: The current count (select 1, read-only; writes are ignored) decrements by one on each divided tick while non-zero; in one-shot mode it stops at 0.
- R4: When the count steps from 1, an interrupt is raised only if software-enable is high and the timer entry's mask is clear; irq_valid is high for exactly one cycle, the cycle in which the count register takes its new value, and irq_vector then holds the timer entry's vector.
- R5: With the timer entry's periodic bit set, expiry reloads the current count from the initial count instead of stopping, so expiries repeat every initial-count divided ticks.
- R6: While software-enable is low, the mask bit of all six entries is set from the next cycle on, and entry writes store the mask set regardless of data; the masks stay set after enable returns until rewritten.
- R7: After reset the initial count, current count and divide register read 0, every entry reads mask set with vector 0 and periodic clear, and irq_valid is low.
- R8: An initial count of 0 leaves the timer idle: the count stays 0 and no interrupt is raised.
- R9: Select codes are 0 initial count, 1 current count, 2 divide, 3 to 8 entries 0 to 5 (entry 0 is the timer); an entry word holds the vector in bits 7:0, the mask in bit 16 and, on entry 0 only, the periodic bit in bit 17; other bits and unused selects read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_tick | input | 1 | Timebase strobe, one pulse per bus tick |
| sw_enable | input | 1 | Global software enable; low forces all entries masked |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 4 | Register select for reads |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request pulse |
| irq_vector | output | 8 | Vector accompanying irq_valid |

## Verification
The checker watches, on every cycle, that a count load takes the written value, that the count never moves by more than one step away from a reload, that an idle count stays at zero, that each request follows a count of 1 under enable with the mask clear and leaves the count reloaded or zero by mode, that a low enable masks all six entries, and that a zero initial count never yields a request. The exact divided-tick spacing for each of the eight divide codes, the register field layout, the read-only nature of the current count and the persistence of forced masks after enable returns are shown only by the bench's scenarios compared against its reference model.

// File: rtl/ictimer_pkg.sv
// Package: shared constants and the entry type of the countdown timer.
// Assumes a 4-bit register select and 32-bit data words.
package ictimer_pkg;
    localparam int SEL_W       = 4;
    localparam int SEL_INIT    = 0;
    localparam int SEL_CUR     = 1;
    localparam int SEL_DIV     = 2;
    localparam int SEL_LVT0    = 3;
    localparam int MASK_BIT    = 16;
    localparam int PER_BIT     = 17;
    localparam int DIV_CODE_W  = 3;

    // Pack the divide register bits {3,1,0} into the 3-bit code.
    function automatic logic [DIV_CODE_W-1:0] div_code(input logic [3:0] cfg);
        return {cfg[3], cfg[1], cfg[0]};
    endfunction
endpackage

// File: rtl/timer_prescale.sv
// Prescaler: counts bus ticks since the last restart and emits a divided
// tick on every 2^((code+1) mod 2^CODE_W)-th one. Assumes the counter
// width equals the largest shift so that it wraps on a multiple of every ratio.
module timer_prescale #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              div_tick
);
    localparam int PRE_W = (1 << CODE_W) - 1;

    logic [PRE_W-1:0]  pre_q;
    logic [CODE_W-1:0] shift;
    logic [PRE_W:0]    mask_wide;
    logic [PRE_W-1:0]  sel_mask;

    // Shift amount wraps so the top code selects ratio 1.
    always_comb begin
        shift     = code + CODE_W'(1);
        mask_wide = ((PRE_W+1)'(1) << shift) - (PRE_W+1)'(1);
        sel_mask  = mask_wide[PRE_W-1:0];
    end

    // Tick counter, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_q <= '0;
        else if (restart) pre_q <= '0;
        else if (tick)    pre_q <= pre_q + PRE_W'(1);
    end

    assign div_tick = tick && !restart && ((pre_q & sel_mask) == sel_mask);
endmodule

// File: rtl/timer_lvt_bank.sv
// Entry bank: NUM entries of vector and mask; entry 0 also holds the periodic
// bit. A low enable forces every mask set and writes land masked.
// Assumes at most one entry is written per cycle (one-hot wr_hit).
module timer_lvt_bank #(
    parameter int NUM   = 6,
    parameter int VEC_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_enable,
    input  logic [NUM-1:0]            wr_hit,
    input  logic [VEC_W-1:0]          wr_vec,
    input  logic                      wr_mask,
    input  logic                      wr_per,
    output logic [NUM-1:0][VEC_W-1:0] vec_o,
    output logic [NUM-1:0]            mask_o,
    output logic                      per0_o
);
    genvar i;
    generate
        for (i = 0; i < NUM; i++) begin : g_ent
            logic [VEC_W-1:0] vec_q;
            logic             mask_q;

            // Vector register of one entry.
            always_ff @(posedge clk) begin
                if (!rst_n)        vec_q <= '0;
                else if (wr_hit[i]) vec_q <= wr_vec;
            end

            // Mask register: forced while disabled, else written.
            always_ff @(posedge clk) begin
                if (!rst_n)         mask_q <= 1'b1;
                else if (!sw_enable) mask_q <= 1'b1;
                else if (wr_hit[i])  mask_q <= wr_mask;
            end

            assign vec_o[i]  = vec_q;
            assign mask_o[i] = mask_q;

            if (i == 0) begin : g_per
                logic per_q;
                // Periodic bit, present on the timer entry only.
                always_ff @(posedge clk) begin
                    if (!rst_n)        per_q <= 1'b0;
                    else if (wr_hit[i]) per_q <= wr_per;
                end
                assign per0_o = per_q;
            end
        end
    endgenerate
endmodule

// File: rtl/timer_countdown.sv
// Countdown core: holds initial and current count, steps on divided ticks,
// reloads or stops at expiry and registers a one-cycle request with vector.
// Assumes load and div_tick are never both high (prescaler gates on restart).
module timer_countdown #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             div_tick,
    input  logic             periodic,
    input  logic             fire_ok,
    input  logic [VEC_W-1:0] vec_in,
    output logic [CNT_W-1:0] cur_o,
    output logic [CNT_W-1:0] init_o,
    output logic             irq_o,
    output logic [VEC_W-1:0] irq_vec_o
);
    logic [CNT_W-1:0] cur_q, init_q;
    logic             expire;

    assign expire = div_tick && !load && (cur_q == CNT_W'(1));

    // Initial count register.
    always_ff @(posedge clk) begin
        if (!rst_n)    init_q <= '0;
        else if (load) init_q <= load_val;
    end

    // Current count: load, step, reload or stop.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cur_q <= '0;
        else if (load)                      cur_q <= load_val;
        else if (expire)                    cur_q <= periodic ? init_q : '0;
        else if (div_tick && cur_q != '0)   cur_q <= cur_q - CNT_W'(1);
    end

    // Request pulse, gated by enable and mask.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= expire && fire_ok;
    end

    // Vector captured with each request.
    always_ff @(posedge clk) begin
        if (!rst_n)                  irq_vec_o <= '0;
        else if (expire && fire_ok)  irq_vec_o <= vec_in;
    end

    assign cur_o  = cur_q;
    assign init_o = init_q;
endmodule

// File: rtl/irq_countdown_timer.sv
// Top: register decode and read mux around prescaler, entry bank and
// countdown core. Assumes DATA_W covers the periodic bit position.
module irq_countdown_timer
    import ictimer_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_LVT = 6,
    parameter int VEC_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_tick,
    input  logic              sw_enable,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    logic                            load_hit;
    logic                            div_hit;
    logic [NUM_LVT-1:0]              lvt_hit;
    logic [3:0]                      div_cfg;
    logic                            div_tick;
    logic [NUM_LVT-1:0][VEC_W-1:0]   lvt_vec;
    logic [NUM_LVT-1:0]              lvt_mask;
    logic                            lvt_per0;
    logic [DATA_W-1:0]               cnt_cur, cnt_init;

    // Write decode.
    always_comb begin
        load_hit = wr_en && (wr_sel == SEL_W'(SEL_INIT));
        div_hit  = wr_en && (wr_sel == SEL_W'(SEL_DIV));
        for (int k = 0; k < NUM_LVT; k++)
            lvt_hit[k] = wr_en && (wr_sel == SEL_W'(SEL_LVT0 + k));
    end

    // Divide register, bit 2 not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_cfg <= '0;
        else if (div_hit) div_cfg <= {wr_data[3], 1'b0, wr_data[1:0]};
    end

    timer_prescale #(.CODE_W(DIV_CODE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (bus_tick),
        .restart  (load_hit),
        .code     (div_code(div_cfg)),
        .div_tick (div_tick)
    );

    timer_lvt_bank #(.NUM(NUM_LVT), .VEC_W(VEC_W)) u_lvt (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_enable (sw_enable),
        .wr_hit    (lvt_hit),
        .wr_vec    (wr_data[VEC_W-1:0]),
        .wr_mask   (wr_data[MASK_BIT]),
        .wr_per    (wr_data[PER_BIT]),
        .vec_o     (lvt_vec),
        .mask_o    (lvt_mask),
        .per0_o    (lvt_per0)
    );

    timer_countdown #(.CNT_W(DATA_W), .VEC_W(VEC_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_hit),
        .load_val  (wr_data),
        .div_tick  (div_tick),
        .periodic  (lvt_per0),
        .fire_ok   (sw_enable && !lvt_mask[0]),
        .vec_in    (lvt_vec[0]),
        .cur_o     (cnt_cur),
        .init_o    (cnt_init),
        .irq_o     (irq_valid),
        .irq_vec_o (irq_vector)
    );

    // Read mux; unused selects and bits return zero.
    always_comb begin
        rd_data = '0;
        case (rd_sel)
            SEL_W'(SEL_INIT): rd_data = cnt_init;
            SEL_W'(SEL_CUR):  rd_data = cnt_cur;
            SEL_W'(SEL_DIV):  rd_data[3:0] = div_cfg;
            default: begin
                for (int k = 0; k < NUM_LVT; k++) begin
                    if (rd_sel == SEL_W'(SEL_LVT0 + k)) begin
                        rd_data[VEC_W-1:0] = lvt_vec[k];
                        rd_data[MASK_BIT]  = lvt_mask[k];
                        if (k == 0) rd_data[PER_BIT] = lvt_per0;
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/timer_checker.sv
// Checker: temporal properties of the countdown timer, bound to the top.
module timer_checker #(
    parameter int CNT_W = 32,
    parameter int NUM   = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_enable,
    input logic             load_hit,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cur_q,
    input logic [CNT_W-1:0] init_q,
    input logic             irq_valid,
    input logic [NUM-1:0]   mask_all,
    input logic             per0
);
    p_restart_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_hit |=> cur_q == $past(wr_data));

    p_oneshot_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == '0 && !load_hit) |=> cur_q == '0);

    p_step_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q > CNT_W'(1) && !load_hit) |=>
            (cur_q == $past(cur_q) || cur_q == $past(cur_q) - CNT_W'(1)));

    p_expire_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ($past(sw_enable) && !$past(mask_all[0]) && $past(cur_q) == CNT_W'(1)));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (cur_q == ($past(per0) ? $past(init_q) : '0)));

    p_forced_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_enable |=> (&mask_all));

    p_zero_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q == '0) |-> !irq_valid);
endmodule

bind irq_countdown_timer timer_checker #(.CNT_W(DATA_W), .NUM(NUM_LVT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_enable (sw_enable),
    .load_hit  (load_hit),
    .wr_data   (wr_data),
    .cur_q     (cnt_cur),
    .init_q    (cnt_init),
    .irq_valid (irq_valid),
    .mask_all  (lvt_mask),
    .per0      (lvt_per0)
);

// File: tb/sim_irq_countdown_timer.sv
module sim_irq_countdown_timer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_tick = 1'b0;
    logic        sw_enable = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0, errors = 0, cyc = 0, irq_seen = 0;
    int tick_mode = 0;
    bit cmp_on = 0;
    string tag = "R7";

    // reference model state
    logic [31:0] m_init, m_cur;
    logic [3:0]  m_div;
    logic [7:0]  m_vec [6];
    bit          m_mask [6];
    bit          m_per, m_irq, m_fire;
    logic [7:0]  m_ivec;
    int          m_ticks, m_ratio, m_idx;

    irq_countdown_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .sw_enable(sw_enable),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, advanced on each rising edge from the requirements.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_init = 0; m_cur = 0; m_div = 0; m_ticks = 0; m_irq = 0; m_ivec = 0; m_per = 0;
            for (int i = 0; i < 6; i++) begin m_vec[i] = 0; m_mask[i] = 1; end
        end else begin
            m_fire = 0;
            m_ratio = 1 << (((m_div[3]*4 + m_div[1]*2 + m_div[0]) + 1) % 8);
            if (wr_en && wr_sel == 0) begin
                m_init = wr_data; m_cur = wr_data; m_ticks = 0;
            end else if (bus_tick) begin
                if ((m_ticks % m_ratio) == m_ratio - 1 && m_cur != 0) begin
                    if (m_cur == 1) begin
                        m_fire = sw_enable && !m_mask[0];
                        m_cur = m_per ? m_init : 0;
                    end else m_cur = m_cur - 1;
                end
                m_ticks = (m_ticks + 1) % 128;
            end
            m_irq = m_fire;
            if (m_fire) m_ivec = m_vec[0];
            if (wr_en && wr_sel == 2) m_div = wr_data[3:0] & 4'b1011;
            if (wr_en && wr_sel >= 3 && wr_sel <= 8) begin
                m_idx = int'(wr_sel) - 3;
                m_vec[m_idx] = wr_data[7:0];
                m_mask[m_idx] = wr_data[16] || !sw_enable;
                if (m_idx == 0) m_per = wr_data[17];
            end
            if (!sw_enable) for (int i = 0; i < 6; i++) m_mask[i] = 1;
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] s);
        logic [31:0] v = 0;
        if (s == 0) v = m_init;
        else if (s == 1) v = m_cur;
        else if (s == 2) v = {28'b0, m_div};
        else if (s <= 8) begin
            v[7:0] = m_vec[s-3];
            v[16] = m_mask[s-3];
            if (s == 3) v[17] = m_per;
        end
        return v;
    endfunction

    // Rotate read select and drive the timebase just after each edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        rd_sel = 4'((cyc) % 10);
        bus_tick = (tick_mode == 0) ? 1'b1 : (cyc % 3 == 0);
    end

    // Compare DUT against model in the middle of each cycle.
    always @(negedge clk) begin
        if (cmp_on) begin
            checks++;
            if (rd_data !== m_read(rd_sel)) begin
                errors++;
                $display("FAIL %s: rd_data sel %0d actual %h expected %h", tag, rd_sel, rd_data, m_read(rd_sel));
            end
            checks++;
            if (irq_valid !== m_irq || (m_irq && irq_vector !== m_ivec)) begin
                errors++;
                $display("FAIL %s: irq actual %b/%h expected %b/%h", tag, irq_valid, irq_vector, m_irq, m_ivec);
            end
            if (irq_valid === 1'b1) irq_seen++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [3:0] s, input logic [31:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        step(1);
        wr_en = 0;
    endtask

    task automatic expect_irqs(input string t, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: interrupt count actual %0d expected %0d", t, got, exp);
        end
    endtask

    initial begin
        step(1); cmp_on = 1; step(3);
        rst_n = 1; step(2);                                // R7 reset state compared

        tag = "R9"; wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF); wr(1, 32'h55); step(12);
        wr(3, 32'h0000_0040); wr(4, 32'h0001_0011); step(12);

        tag = "R1";
        for (int c = 0; c < 8; c++) begin
            wr(2, {28'b0, c[2], 1'b1, c[1:0]});        // bit 2 set, must read 0
            irq_seen = 0;
            wr(0, 5);
            step(5 * (1 << ((c + 1) % 8)) + 4);
            expect_irqs("R1", irq_seen, 1);
        end

        tag = "R3"; wr(2, 0); irq_seen = 0; wr(0, 4); step(20);
        expect_irqs("R3", irq_seen, 1);

        tag = "R8"; irq_seen = 0; wr(0, 0); step(30);
        expect_irqs("R8", irq_seen, 0);

        tag = "R5"; tick_mode = 1; wr(3, 32'h0002_0077); irq_seen = 0; wr(0, 3); step(60);
        checks++;
        if (irq_seen < 3) begin errors++; $display("FAIL R5: periodic interrupts actual %0d expected at least 3", irq_seen); end

        tag = "R2"; tick_mode = 0; wr(0, 40); step(15); wr(0, 2); step(3); wr(0, 0); step(4);

        tag = "R4"; wr(3, 32'h0001_0033); irq_seen = 0; wr(0, 2); step(10);
        expect_irqs("R4", irq_seen, 0);
        wr(3, 32'h0000_0099); irq_seen = 0; wr(0, 2); step(10);
        expect_irqs("R4", irq_seen, 1);

        tag = "R6"; sw_enable = 0; step(3); wr(5, 32'h0000_0012); irq_seen = 0; wr(0, 2); step(12);
        expect_irqs("R6", irq_seen, 0);
        sw_enable = 1; step(12); irq_seen = 0; wr(0, 2); step(10);
        expect_irqs("R6", irq_seen, 0);

        tag = "R7"; rst_n = 0; step(3); rst_n = 1; step(12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule